// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block sits between a processor bus and an ISA-style port bus. Processor accesses that land in an 8 MB I/O window at 0x80000000 become single ISA port cycles. Each cycle carries a 16-bit port number, an access size and write data, and completes on a done handshake. A map-mode input picks how the processor address folds into the port number. In contiguous mode the low 16 bits pass straight through. In non-contiguous mode each 4 KB page of the window supplies a 32-port group.

A big-endian input makes the bridge reverse byte order on 16-bit and 32-bit data in both directions. A separate 4-byte aperture at 0xBFFFFFF0 serves interrupt acknowledge. A read at its first byte fetches a vector from the interrupt controller through its own request and done pair.

Only one access is in flight at a time. The processor holds its request until ready, then drops it in the cycle after ready. Addresses outside both windows get no response at all.

Top module: `isa_io_bridge`

## Requirements
- R1: A processor request with address 0x80000000 to 0x807FFFFF (inclusive) is claimed and raises `isa_req`. Requests outside this window and outside the acknowledge aperture, for example 0x7FFFFFFF and 0x80800000, raise none of `isa_req`, `iack_req` or `cpu_ready`.
- R2: With `map_mode` = 0 at acceptance, `isa_port` equals processor address bits 15:0.
- R3: With `map_mode` = 1 at acceptance, `isa_port` bits 4:0 equal address bits 4:0 and port bits 15:5 equal address bits 22:12.
- R4: The size codes are 0 = byte, 1 = 16-bit and 2 = 32-bit. Data lives in the low bits and the unused upper bits are zero. A byte access is never reordered. A 16-bit access swaps its two bytes in both directions when `big_endian` = 1 at acceptance, and is passed unchanged otherwise.
- R5: A 32-bit access reverses all four bytes in both directions when `big_endian` = 1, and passes them unchanged when it is 0.
- R6: A read at 0xBFFFFFF0 raises `iack_req` and not `isa_req`. It returns `iack_vec` zero-extended, then byte-ordered by size and endianness as in R4 and R5.
- R7: A read at 0xBFFFFFF1 to 0xBFFFFFF3 returns 0, and any write into 0xBFFFFFF0 to 0xBFFFFFF3 is discarded. Both complete with `cpu_ready` one cycle after acceptance and raise no port or acknowledge request.
- R8: `isa_req` rises one cycle after acceptance and stays high until the cycle in which `isa_done` is seen. `cpu_ready` is high with `cpu_rdata` for exactly one cycle, in the cycle after done.
- R9: While an access is in flight, changes on the processor inputs and on `map_mode` and `big_endian` do not alter the port, size, direction, write data or read ordering of that access.
- R10: During reset `isa_req`, `iack_req` and `cpu_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_mode | input | 1 | 0 contiguous fold, 1 page fold |
| big_endian | input | 1 | Enable byte reordering |
| cpu_req | input | 1 | Processor request |
| cpu_addr | input | 32 | Processor address |
| cpu_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion |
| cpu_rdata | output | 32 | Read data, valid with ready |
| isa_req | output | 1 | Port cycle request, held to done |
| isa_port | output | 16 | Port number |
| isa_size | output | 2 | Port cycle size |
| isa_we | output | 1 | Port cycle direction |
| isa_wdata | output | 32 | Port write data |
| isa_done | input | 1 | Port cycle complete |
| isa_rdata | input | 32 | Port read data, taken with done |
| iack_req | output | 1 | Vector fetch request, held to done |
| iack_done | input | 1 | Vector fetch complete |
| iack_vec | input | 8 | Interrupt vector, taken with done |

## Verification
Port and acknowledge requests are due one cycle after the accepting edge. The bench checks them at the falling edge that follows, including the port number and the reordered write data. Ready is due one cycle after the edge that sees done, or one cycle after acceptance for the aperture paths that answer at once. The bench samples ready there, checks that it drops one cycle later, and confirms that the requests stay held across a variable number of wait cycles. The processor inputs and mode pins are perturbed during that wait, and the bench checks that the in-flight access does not change.

// File: rtl/iob_pkg.sv
package iob_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ISA  = 2'd1,
    ST_IACK = 2'd2,
    ST_RESP = 2'd3
  } iob_state_e;
endpackage

// File: rtl/iob_addr_map.sv
module iob_addr_map #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PORT_W      = 16,
  parameter int unsigned IO_WIN_BITS = 23,
  parameter logic [ADDR_W-1:0] IO_BASE   = 32'h8000_0000,
  parameter int unsigned IACK_OFF_BITS = 2,
  parameter logic [ADDR_W-1:0] IACK_BASE = 32'hBFFF_FFF0,
  parameter int unsigned NC_LOW_BITS = 5,
  parameter int unsigned NC_PAGE_LSB = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_fold,
  output logic              io_hit,
  output logic              iack_hit,
  output logic              iack_first,
  output logic [PORT_W-1:0] port
);
  localparam int unsigned NC_PAGE_BITS = PORT_W - NC_LOW_BITS;
  localparam int unsigned NC_PAGE_MSB  = NC_PAGE_LSB + NC_PAGE_BITS - 1;
  localparam logic [ADDR_W-IO_WIN_BITS-1:0]   IO_TAG   = IO_BASE[ADDR_W-1:IO_WIN_BITS];
  localparam logic [ADDR_W-IACK_OFF_BITS-1:0] IACK_TAG = IACK_BASE[ADDR_W-1:IACK_OFF_BITS];

  logic [PORT_W-1:0] port_flat;
  logic [PORT_W-1:0] port_paged;

  always_comb begin
    io_hit     = (addr[ADDR_W-1:IO_WIN_BITS] == IO_TAG);
    iack_hit   = (addr[ADDR_W-1:IACK_OFF_BITS] == IACK_TAG);
    iack_first = (addr[IACK_OFF_BITS-1:0] == '0);
    port_flat  = addr[PORT_W-1:0];
    port_paged = {addr[NC_PAGE_MSB:NC_PAGE_LSB], addr[NC_LOW_BITS-1:0]};
    port       = page_fold ? port_paged : port_flat;
  end
endmodule

// File: rtl/iob_lane_swap.sv
module iob_lane_swap
  import iob_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              swap_en,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] reversed;

  for (genvar i = 0; i < NBYTES; i++) begin : g_rev
    assign reversed[8*i +: 8] = din[8*(NBYTES-1-i) +: 8];
  end

  always_comb begin
    dout = '0;
    case (size)
      SZ_BYTE: dout[7:0] = din[7:0];
      SZ_HALF: dout[15:0] = swap_en ? {din[7:0], din[15:8]} : din[15:0];
      default: dout = swap_en ? reversed : din;
    endcase
  end
endmodule

// File: rtl/iob_ctrl.sv
module iob_ctrl
  import iob_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic io_hit,
  input  logic iack_hit,
  input  logic iack_first,
  input  logic isa_done,
  input  logic iack_done,
  output logic accept,
  output logic fetch_isa,
  output logic fetch_iack,
  output logic isa_req,
  output logic iack_req,
  output logic cpu_ready
);
  iob_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req && io_hit) begin
          accept  = 1'b1;
          state_d = ST_ISA;
        end else if (cpu_req && iack_hit) begin
          accept  = 1'b1;
          state_d = (!cpu_we && iack_first) ? ST_IACK : ST_RESP;
        end
      end
      ST_ISA:  if (isa_done)  state_d = ST_RESP;
      ST_IACK: if (iack_done) state_d = ST_RESP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign isa_req    = (state_q == ST_ISA);
  assign iack_req   = (state_q == ST_IACK);
  assign cpu_ready  = (state_q == ST_RESP);
  assign fetch_isa  = isa_req && isa_done;
  assign fetch_iack = iack_req && iack_done;

  // R8: ready lasts one cycle
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R8: port request held until done
  p_hold_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isa_req && !isa_done |=> isa_req);
  // R9: one outstanding access
  p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isa_req, iack_req, cpu_ready}));
  // R1: misses are not claimed
  p_miss_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_req && !iack_req && !cpu_ready && cpu_req && !io_hit && !iack_hit)
    |=> (!isa_req && !iack_req && !cpu_ready));
  // R7: aperture writes and non-zero offsets answer at once
  p_iack_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_req && !iack_req && !cpu_ready && cpu_req && !io_hit && iack_hit
     && (cpu_we || !iack_first)) |=> (cpu_ready && !iack_req));
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge
  import iob_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PORT_W = 16,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_mode,
  input  logic              big_endian,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              isa_req,
  output logic [PORT_W-1:0] isa_port,
  output logic [1:0]        isa_size,
  output logic              isa_we,
  output logic [DATA_W-1:0] isa_wdata,
  input  logic              isa_done,
  input  logic [DATA_W-1:0] isa_rdata,
  output logic              iack_req,
  input  logic              iack_done,
  input  logic [VEC_W-1:0]  iack_vec
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic              io_hit, iack_hit, iack_first;
  logic [PORT_W-1:0] fold_port;
  logic              accept, fetch_isa, fetch_iack;
  logic [DATA_W-1:0] wr_ordered, rd_raw, rd_ordered;

  logic [PORT_W-1:0] port_q;
  logic [1:0]        size_q;
  logic              we_q, be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  iob_addr_map #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_map (
    .addr(cpu_addr), .page_fold(map_mode), .io_hit(io_hit),
    .iack_hit(iack_hit), .iack_first(iack_first), .port(fold_port)
  );

  iob_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .io_hit(io_hit), .iack_hit(iack_hit), .iack_first(iack_first),
    .isa_done(isa_done), .iack_done(iack_done), .accept(accept),
    .fetch_isa(fetch_isa), .fetch_iack(fetch_iack), .isa_req(isa_req),
    .iack_req(iack_req), .cpu_ready(cpu_ready)
  );

  iob_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .din(cpu_wdata), .size(cpu_size), .swap_en(big_endian), .dout(wr_ordered)
  );

  assign rd_raw = fetch_iack ? {{(DATA_W-VEC_W){1'b0}}, iack_vec} : isa_rdata;

  iob_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .din(rd_raw), .size(size_q), .swap_en(be_q), .dout(rd_ordered)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      port_q  <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      port_q  <= fold_port;
      size_q  <= cpu_size;
      we_q    <= cpu_we;
      be_q    <= big_endian;
      wdata_q <= wr_ordered;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                    rdata_q <= '0;
    else if (accept)                   rdata_q <= '0;
    else if (fetch_isa || fetch_iack)  rdata_q <= rd_ordered;
  end

  assign cpu_rdata = rdata_q;
  assign isa_port  = port_q;
  assign isa_size  = size_q;
  assign isa_we    = we_q;
  assign isa_wdata = wdata_q;

  // R9: in-flight port number is frozen
  p_port_frozen_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    isa_req && !isa_done |=> $stable(isa_port) && $stable(isa_wdata));
  // R2: contiguous fold seen on the port
  p_flat_fold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(isa_req) && !$past(map_mode) |-> isa_port == $past(cpu_addr[PORT_W-1:0]));
  // R4: byte writes are not reordered
  p_byte_plain_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(isa_req) && isa_we && isa_size == 2'd0
    |-> isa_wdata == {{(DATA_W-8){1'b0}}, $past(cpu_wdata[7:0])});
  // R10: quiet while reset is applied
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_int_n |-> !isa_req && !iack_req && !cpu_ready);
endmodule

// File: tb/isa_io_bridge_bench.sv
module isa_io_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_mode, big_endian;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [1:0]  cpu_size;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        isa_req, isa_we;
  logic [15:0] isa_port;
  logic [1:0]  isa_size;
  logic [31:0] isa_wdata, isa_rdata;
  logic        isa_done;
  logic        iack_req, iack_done;
  logic [7:0]  iack_vec;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_io_bridge u_isa_io_bridge (
    .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .big_endian(big_endian),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .isa_req(isa_req), .isa_port(isa_port),
    .isa_size(isa_size), .isa_we(isa_we), .isa_wdata(isa_wdata),
    .isa_done(isa_done), .isa_rdata(isa_rdata), .iack_req(iack_req),
    .iack_done(iack_done), .iack_vec(iack_vec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_order(input logic [31:0] d,
                                            input logic [1:0] sz, input bit be);
    if (sz == 2'd0) return d & 32'h0000_00FF;
    if (sz == 2'd1) return be ? (((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF))
                              : (d & 32'h0000_FFFF);
    return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  function automatic logic [15:0] exp_port(input logic [31:0] a, input bit pg);
    logic [31:0] v;
    v = pg ? ((a & 32'h1F) | ((a & 32'h007F_F000) >> 7)) : (a & 32'hFFFF);
    return v[15:0];
  endfunction

  task automatic io_access(input logic [31:0] a, input logic [1:0] sz,
                           input bit we, input logic [31:0] wd, input bit pg,
                           input bit be, input int wait_n, input logic [31:0] rd);
    logic [15:0] p;
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
    map_mode = pg; big_endian = be;
    @(negedge clk);
    chk(isa_req && !cpu_ready && !iack_req, "R8 req after accept", {31'b0, isa_req}, 1);
    chk(isa_port == exp_port(a, pg), pg ? "R3 page fold" : "R2 flat fold",
        {16'b0, isa_port}, {16'b0, exp_port(a, pg)});
    chk(isa_size == sz && isa_we == we, "R1 size/dir", {29'b0, isa_we, isa_size},
        {29'b0, we, sz});
    if (we)
      chk(isa_wdata == exp_order(wd, sz, be), sz == 2'd2 ? "R5 write order" : "R4 write order",
          isa_wdata, exp_order(wd, sz, be));
    p = isa_port;
    cpu_addr = a ^ 32'h0000_5A5A; cpu_wdata = ~wd; map_mode = !pg; big_endian = !be;
    cpu_size = sz ^ 2'd1; cpu_we = !we;
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk(isa_req && isa_port == p && !cpu_ready, "R9 held while busy",
          {16'b0, isa_port}, {16'b0, p});
    end
    isa_done = 1; isa_rdata = rd;
    @(negedge clk);
    isa_done = 0; isa_rdata = '0;
    chk(cpu_ready && !isa_req, "R8 ready after done", {31'b0, cpu_ready}, 1);
    if (!we)
      chk(cpu_rdata == exp_order(rd, sz, be), sz == 2'd2 ? "R5 read order" : "R4 read order",
          cpu_rdata, exp_order(rd, sz, be));
    cpu_req = 0;
    @(negedge clk);
    chk(!cpu_ready && !isa_req, "R8 single ready", {31'b0, cpu_ready}, 0);
  endtask

  task automatic iack_access(input logic [1:0] off, input logic [1:0] sz,
                             input bit we, input bit be, input logic [7:0] vec);
    logic [31:0] e;
    @(negedge clk);
    cpu_req = 1; cpu_addr = 32'hBFFF_FFF0 | {30'b0, off}; cpu_size = sz;
    cpu_we = we; cpu_wdata = 32'hDEAD_BEEF; big_endian = be;
    @(negedge clk);
    if (!we && off == 2'd0) begin
      chk(iack_req && !isa_req && !cpu_ready, "R6 vector fetch", {31'b0, iack_req}, 1);
      iack_done = 1; iack_vec = vec;
      @(negedge clk);
      iack_done = 0; iack_vec = '0;
      e = exp_order({24'b0, vec}, sz, be);
      chk(cpu_ready && cpu_rdata == e, "R6 vector data", cpu_rdata, e);
    end else begin
      chk(cpu_ready && !iack_req && !isa_req, "R7 direct answer", {31'b0, cpu_ready}, 1);
      if (!we) chk(cpu_rdata == 0, "R7 zero read", cpu_rdata, 0);
    end
    cpu_req = 0;
    @(negedge clk);
    chk(!cpu_ready, "R8 single ready", {31'b0, cpu_ready}, 0);
  endtask

  task automatic miss_access(input logic [31:0] a);
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_size = 2'd0; cpu_we = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!isa_req && !iack_req && !cpu_ready, "R1 miss unclaimed",
          {29'b0, isa_req, iack_req, cpu_ready}, 0);
    end
    cpu_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; map_mode = 0; big_endian = 0; cpu_req = 0; cpu_we = 0;
    cpu_addr = '0; cpu_wdata = '0; cpu_size = '0; isa_done = 0; isa_rdata = '0;
    iack_done = 0; iack_vec = '0;
    repeat (3) @(negedge clk);
    chk(!isa_req && !iack_req && !cpu_ready, "R10 reset quiet",
        {29'b0, isa_req, iack_req, cpu_ready}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!isa_req && !iack_req && !cpu_ready, "R10 after release",
        {29'b0, isa_req, iack_req, cpu_ready}, 0);

    for (int pg = 0; pg < 2; pg++)
      for (int be = 0; be < 2; be++)
        for (int sz = 0; sz < 3; sz++)
          for (int we = 0; we < 2; we++)
            for (int k = 0; k < 4; k++) begin
              logic [31:0] a;
              logic [31:0] off;
              off = (k * 32'h0002_A5C3 + pg * 32'h0013_1071 + sz * 32'h0000_0F0F
                     + be * 32'h0055_3301) & 32'h007F_FFFF;
              if (k == 0) off = 32'h0;
              if (k == 3) off = 32'h007F_FFFF;
              a = 32'h8000_0000 | off;
              io_access(a, sz[1:0], we[0], 32'hA1B2_C3D4 ^ (off << 3), pg[0], be[0],
                        k, 32'h1357_9BDF ^ off);
            end

    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int we = 0; we < 2; we++)
            iack_access(off[1:0], sz[1:0], we[0], be[0], 8'h40 + 8'(off * 7 + sz));

    miss_access(32'h7FFF_FFFF);
    miss_access(32'h8080_0000);
    miss_access(32'hBFFF_FFEC);
    miss_access(32'hBFFF_FFF4);
    miss_access(32'h0000_0000);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule